// File: doc/BRIEF.md
# Two-Way Secondary Cache Tag Controller

This block does the tag lookup and picks the replacement way for a 256 KiB, two-way set-associative secondary cache. The cache has 32-byte lines and serves a 32-bit physical address bus. The cache has 4096 sets. For each request the block splits the address into a byte offset, a set index and a tag. It reads a single tag-RAM word at the set index. That word holds the tags of both ways and one shared least-recently-used (LRU) bit. The block compares both stored tags with the request tag in parallel and reports hit or miss together with a way number.

A hit is followed at once by a write-back of the same word, with the LRU bit changed to name the other way. A miss raises a fill request that names the victim way and holds the set. When the fill-done input arrives, the block commits three things in its write-back cycle: the new tag in the victim slot, an LRU bit pointing away from the victim, and the victim's valid flag. Valid flags live in a flop array inside the block and are cleared by reset. The tag RAM itself sits outside the block and is reached through a simple read/write port with one cycle of read latency.

Top module: `l2_tag_ctrl`

## Requirements
- R1: The set index is address bits [16:5], the compared tag is bits [31:17], and bits [4:0] never change the outcome. Two addresses that differ only in [4:0] give the same result.
- R2: In the cycle a request is accepted (req_valid and req_ready both high), tram_rd is 1 and tram_addr equals the set index of req_addr.
- R3: The cycle after acceptance, resp_valid is 1 for exactly that cycle. resp_hit is 1 when a valid way's stored tag equals the request tag, and resp_way then gives that way (0 or 1).
- R4: A way whose valid flag is clear never hits, even if its stored tag matches. Reset clears every valid flag but leaves the tag RAM unchanged.
- R5: After a hit, the next cycle has tram_wr = 1 at the same set. The write data keeps both tags unchanged and sets the LRU bit (word bit 30) to the way that did not hit. The word layout is {lru[30], tag_way1[29:15], tag_way0[14:0]}.
- R6: On a miss, resp_way gives the victim. If a way is invalid, the victim is that way, with way 0 chosen first. If both ways are valid, the victim is the way named by the LRU bit.
- R7: After a miss, fill_req is 1 from the cycle after resp_valid, with fill_way equal to the victim. fill_req stays high and fill_way stays fixed until fill_done. No tag-RAM write happens during this time.
- R8: The cycle after fill_done is sampled high, tram_wr is 1. The write data carries the request tag in the victim's slot, the other tag unchanged, and LRU set to the non-victim way. From then on the victim way is valid.
- R9: req_ready is low from the cycle after acceptance until the write-back cycle has passed. It is high again in the cycle after the write.
- R10: While reset is asserted, req_ready, tram_rd, tram_wr, resp_valid and fill_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 32 | Physical byte address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Lookup result valid this cycle |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 1 | Hit way on a hit, victim way on a miss |
| fill_req | output | 1 | Line fill requested; the set is held |
| fill_way | output | 1 | Way being filled |
| fill_done | input | 1 | Fill has finished; commit the new tag |
| tram_rd | output | 1 | Tag-RAM read strobe |
| tram_wr | output | 1 | Tag-RAM write strobe |
| tram_addr | output | 12 | Tag-RAM set address |
| tram_wdata | output | 31 | Tag-RAM write word {lru, tag1, tag0} |
| tram_rdata | input | 31 | Tag-RAM read word, valid one cycle after tram_rd |

## Verification
Each result has a fixed due cycle relative to a request:
- The tag-RAM read strobe and set address appear in the acceptance cycle.
- The hit, way and victim result appears one cycle later.
- A hit's write-back appears one cycle after that.
- A fill's write-back appears one cycle after fill_done is sampled.

The bench drives inputs at the falling edge and checks each output at the falling edge of exactly its due cycle. During a fill wait of chosen length it also checks, every cycle, that no write happens. A bench-side model of tags, valid flags and LRU, together with a registered tag-RAM model, supplies the expected hit, way and write word.

// File: rtl/l2_tag_pkg.sv
package l2_tag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FILL = 2'd2,
    ST_WB   = 2'd3
  } tag_state_e;
endpackage

// File: rtl/l2_tag_split.sv
module l2_tag_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 12,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  // Byte offset bits are dropped; index selects the set, the rest is compared.
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/l2_tag_match.sv
module l2_tag_match #(
  parameter int TAG_W = 15,
  localparam int WAYS   = 2,
  localparam int WORD_W = WAYS*TAG_W + 1
) (
  input  logic [WORD_W-1:0] rd_word,
  input  logic [WAYS-1:0]   way_valid,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic              hit_way,
  output logic              victim_way
);
  logic [WAYS-1:0] tag_hit;
  logic            lru;

  assign lru = rd_word[WORD_W-1];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_hit[w] = way_valid[w] && (rd_word[w*TAG_W +: TAG_W] == tag);
  end

  assign hit     = |tag_hit;
  assign hit_way = ~tag_hit[0];

  always_comb begin
    if (!way_valid[0])      victim_way = 1'b0;
    else if (!way_valid[1]) victim_way = 1'b1;
    else                    victim_way = lru;
  end
endmodule

// File: rtl/l2_tag_valid.sv
module l2_tag_valid #(
  parameter int IDX_W = 12,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_valid,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_way
);
  logic [1:0] vld_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= 2'b00;
    end else if (set_en) begin
      vld_q[set_idx][set_way] <= 1'b1;
    end
  end

  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2_tag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 12,
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
  localparam int WORD_W  = 2*TAG_W + 1,
  localparam int LRU_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_way,
  output logic              fill_req,
  output logic              fill_way,
  input  logic              fill_done,
  output logic              tram_rd,
  output logic              tram_wr,
  output logic [IDX_W-1:0]  tram_addr,
  output logic [WORD_W-1:0] tram_wdata,
  input  logic [WORD_W-1:0] tram_rdata
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tag_state_e state_q, state_d;
  logic [IDX_W-1:0]  req_idx, idx_q;
  logic [TAG_W-1:0]  req_tag, tag_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic              miss_q, victim_q;
  logic [1:0]        valid_rd;
  logic              hit, hit_way, victim_way;
  logic              accept, in_look;

  l2_tag_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .addr (req_addr),
    .idx  (req_idx),
    .tag  (req_tag)
  );

  l2_tag_valid #(.IDX_W(IDX_W)) u_valid (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_idx   (idx_q),
    .rd_valid (valid_rd),
    .set_en   (tram_wr && miss_q),
    .set_idx  (idx_q),
    .set_way  (victim_q)
  );

  l2_tag_match #(.TAG_W(TAG_W)) u_match (
    .rd_word    (tram_rdata),
    .way_valid  (valid_rd),
    .tag        (tag_q),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  assign req_ready = (state_q == ST_IDLE) && rst_sync_n;
  assign accept    = req_valid && req_ready;
  assign in_look   = (state_q == ST_LOOK);

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: state_d = hit ? ST_WB : ST_FILL;
      ST_FILL: if (fill_done) state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Write-back word: hit flips LRU away from the hit way; miss places the
  // new tag in the victim slot and points LRU at the other way.
  always_comb begin
    if (hit)
      word_d = {~hit_way, tram_rdata[WORD_W-2:0]};
    else if (victim_way)
      word_d = {1'b0, tag_q, tram_rdata[TAG_W-1:0]};
    else
      word_d = {1'b1, tram_rdata[2*TAG_W-1:TAG_W], tag_q};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      tag_q    <= '0;
      word_q   <= '0;
      miss_q   <= 1'b0;
      victim_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        idx_q <= req_idx;
        tag_q <= req_tag;
      end
      if (in_look) begin
        word_q   <= word_d;
        miss_q   <= ~hit;
        victim_q <= victim_way;
      end
    end
  end

  assign resp_valid = in_look;
  assign resp_hit   = in_look && hit;
  assign resp_way   = hit ? hit_way : victim_way;
  assign fill_req   = (state_q == ST_FILL);
  assign fill_way   = victim_q;
  assign tram_rd    = accept;
  assign tram_wr    = (state_q == ST_WB);
  assign tram_addr  = (state_q == ST_IDLE) ? req_idx : idx_q;
  assign tram_wdata = word_q;

  // Assertions
  // R3: a reported hit is backed by the stored tag of the reported way
  a_r3_hit_tag_matches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid && resp_hit |->
      (resp_way ? tram_rdata[2*TAG_W-1:TAG_W] : tram_rdata[TAG_W-1:0]) == tag_q);

  // R4: a hit way must be valid
  a_r4_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid && resp_hit |-> valid_rd[resp_way]);

  // R5: hit write-back follows and points LRU at the other way
  a_r5_hit_writeback: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid && resp_hit |=> tram_wr && (tram_wdata[LRU_BIT] == !$past(resp_way)));

  // R6: with both ways valid, the miss victim is the LRU way
  a_r6_victim_lru: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid && !resp_hit && (valid_rd == 2'b11) |-> resp_way == tram_rdata[LRU_BIT]);

  // R6: an invalid way 0 is always chosen first
  a_r6_victim_invalid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    resp_valid && !resp_hit && !valid_rd[0] |-> resp_way == 1'b0);

  // R7: fill request holds until fill_done, with no tag write meanwhile
  a_r7_fill_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_req && !fill_done |=> fill_req && $stable(fill_way));

  a_r7_no_write_in_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_req |-> !tram_wr);

  // R8: fill commit writes with LRU pointing away from the victim
  a_r8_fill_commit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_req && fill_done |=> tram_wr && (tram_wdata[LRU_BIT] != $past(fill_way)));

  // R9: no new request is taken while a lookup is in flight
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (resp_valid || fill_req || tram_wr) |-> !req_ready);
endmodule

// File: tb/l2_tag_ctrl_tb.sv
module l2_tag_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, fill_done;
  logic [31:0] req_addr;
  logic        req_ready, resp_valid, resp_hit, resp_way, fill_req, fill_way;
  logic        tram_rd, tram_wr;
  logic [11:0] tram_addr;
  logic [30:0] tram_wdata;
  logic [30:0] tram_rdata;

  always #4 clk = ~clk;  // 125 MHz

  l2_tag_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .fill_req(fill_req), .fill_way(fill_way),
    .fill_done(fill_done), .tram_rd(tram_rd), .tram_wr(tram_wr),
    .tram_addr(tram_addr), .tram_wdata(tram_wdata), .tram_rdata(tram_rdata)
  );

  // Tag RAM model: one cycle of read latency
  bit [30:0] mem [4096];
  always @(posedge clk) begin
    if (tram_rd) tram_rdata <= mem[tram_addr];
    if (tram_wr) mem[tram_addr] <= tram_wdata;
  end

  // Reference state
  bit [14:0] m_tag [4096][2];
  bit        m_val [4096][2];
  bit        m_lru [4096];

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit [30:0] exp_word(input int s);
    return {m_lru[s], m_tag[s][1], m_tag[s][0]};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: quiet outputs while in reset
    chk("R10 ready", req_ready, 0);
    chk("R10 rd", tram_rd, 0);
    chk("R10 wr", tram_wr, 0);
    chk("R10 resp", resp_valid, 0);
    chk("R10 fill", fill_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 4096; s++) begin
      m_val[s][0] = 1'b0;
      m_val[s][1] = 1'b0;
    end
  endtask

  task automatic access(input logic [31:0] a, input int dly);
    int        s;
    bit [14:0] t;
    bit        h0, h1, eh, ew;
    s  = int'(a[16:5]);
    t  = a[31:17];
    h0 = m_val[s][0] && (m_tag[s][0] == t);
    h1 = m_val[s][1] && (m_tag[s][1] == t);
    eh = h0 || h1;
    if (eh)              ew = h0 ? 1'b0 : 1'b1;
    else if (!m_val[s][0]) ew = 1'b0;
    else if (!m_val[s][1]) ew = 1'b1;
    else                 ew = m_lru[s];

    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    chk("R9 ready idle", req_ready, 1);
    chk("R2 rd strobe", tram_rd, 1);
    chk("R1 R2 set index", tram_addr, s);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R3 resp_valid", resp_valid, 1);
    chk("R3 R4 hit", resp_hit, eh);
    chk(eh ? "R3 hit way" : "R6 victim way", resp_way, ew);
    chk("R9 busy", req_ready, 0);
    if (eh) begin
      m_lru[s] = ~ew;
      @(negedge clk);
      #1;
      chk("R5 wr", tram_wr, 1);
      chk("R5 addr", tram_addr, s);
      chk("R5 word", tram_wdata, exp_word(s));
    end else begin
      @(negedge clk);
      #1;
      chk("R7 fill_req", fill_req, 1);
      chk("R7 fill_way", fill_way, ew);
      chk("R3 resp one cycle", resp_valid, 0);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        #1;
        chk("R7 hold", fill_req, 1);
        chk("R7 no write", tram_wr, 0);
      end
      fill_done = 1'b1;
      @(negedge clk);
      fill_done = 1'b0;
      #1;
      m_tag[s][ew] = t;
      m_val[s][ew] = 1'b1;
      m_lru[s]     = ~ew;
      chk("R8 wr", tram_wr, 1);
      chk("R8 addr", tram_addr, s);
      chk("R8 word", tram_wdata, exp_word(s));
    end
    @(negedge clk);
    #1;
    chk("R9 ready again", req_ready, 1);
  endtask

  function automatic logic [31:0] mk(input int tg, input int st, input int off);
    return {tg[14:0], st[11:0], off[4:0]};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    fill_done = 1'b0;
    do_reset();

    // Directed corner cases
    access(mk(0, 7, 0), 0);          // R4: stored tag 0 matches RAM but invalid -> miss
    access(mk(3, 5, 0), 2);          // R6: both invalid -> way 0
    access(mk(3, 5, 31), 0);         // R1: offset ignored -> hit way 0
    access(mk(9, 5, 4), 1);          // R6: way 1 invalid -> way 1
    access(mk(3, 5, 8), 0);          // R5: hit way 0, lru -> 1
    access(mk(11, 5, 0), 3);         // R6: both valid, lru=1 replaces tag 9
    access(mk(9, 5, 0), 0);          // lru now 0 -> replaces tag 3
    access(mk(11, 5, 0), 0);         // R3: hit way 1
    access(mk(15'h7FFF, 4095, 31), 1); // top set and tag
    access(mk(15'h7FFF, 4095, 0), 0);

    // R4: reset clears valid flags while RAM keeps the tags
    do_reset();
    access(mk(11, 5, 0), 0);
    access(mk(11, 5, 2), 0);

    // Random traffic over a few sets and tags
    for (int i = 0; i < 300; i++) begin
      int tg, st, off, dl;
      tg  = int'($urandom_range(0, 5));
      st  = int'($urandom_range(0, 3));
      off = int'($urandom_range(0, 31));
      dl  = int'($urandom_range(0, 3));
      access(mk(tg, st, off), dl);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule